// File: doc/BRIEF.md
# SIMT Divergence Mask Unit

This block tracks which lanes of one warp are live while the warp's shared instruction stream passes through data-dependent control flow. Lane `i` carries thread `i` of the warp, so a per-thread condition arrives as one bit per lane. When the lanes disagree on a branch, both sides are run one after the other. The then-side runs with the lanes whose condition bit is set. The else-side runs with the complementary lanes. At the join point the lanes that were live before the branch are live again.

Loops use the same mechanism. Each exit test removes the lanes that leave. When none are left, the mask that was live before the loop comes back and a completion pulse tells the sequencer to fall through. Nested regions keep their restore masks on a small stack of frames. A branch whose outcome is the same for every live lane creates no frame and raises a uniform-outcome pulse, so the sequencer can jump over the unused side.

Top module: `simt_mask_unit`

## Requirements
- R1: While reset is high, and at the first clock edge after it, the active mask is all ones, every flag is low and the stack holds no frames.
- R2: A divergent branch (command code 1) sets the active mask on the next clock edge to the old mask ANDed with `cmd_cond`, where bit `i` belongs to thread `i`. An even-thread condition therefore gives 0x55555555.
- R3: An else command (code 2), issued while the top frame comes from a branch, sets the mask to the lanes that were live at the branch and had a clear condition bit. After R2's even split this is 0xAAAAAAAA.
- R4: A join command (code 3), issued while the top frame comes from a branch, restores the mask that was live when that branch was issued and removes the frame.
- R5: A branch whose condition selects none of the live lanes pulses `none_go` for one cycle. One that selects all of them pulses `all_go` for one cycle. In both cases the mask does not change and no frame is pushed.
- R6: Branches nest. A join of an inner branch restores the mask of the enclosing path, not the full warp.
- R7: A loop-enter command (code 4) pushes a loop frame and leaves the mask unchanged. A loop-exit command (code 5) removes the lanes whose `cmd_cond` bit is set.
- R8: When a loop-exit leaves no live lane, the mask returns to the value it had at loop-enter, the loop frame is removed, and `loop_done` pulses for one cycle.
- R9: A push with all DEPTH frames in use leaves the mask and the stack unchanged and sets `ovf_err`. The flag stays set until reset.
- R10: Else or join with no branch frame on top, and loop-exit with no loop frame on top, leave the mask and the stack unchanged.
- R11: While any frame is held, the active mask is a subset of the restore mask stored in the top frame.
- R12: With `cmd_valid` low, or with command code 0, 6 or 7, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 0 none, 1 branch, 2 else, 3 join, 4 loop-enter, 5 loop-exit |
| cmd_cond | input | LANES | Per-lane condition; bit i belongs to thread i |
| act_mask | output | LANES | Currently live lanes |
| all_go | output | 1 | One-cycle pulse: branch selected every live lane |
| none_go | output | 1 | One-cycle pulse: branch selected no live lane |
| loop_done | output | 1 | One-cycle pulse: the last live lane left the loop |
| ovf_err | output | 1 | Sticky stack-overflow flag |

## Verification
The bench builds the block with 32 lanes and a stack depth of 4. The full warp width lets the even/odd split produce the exact alternating masks. The shallow stack is filled with four loop frames in a few commands. That puts both overflow and a uniform branch at full depth within reach: the first must raise the sticky flag, and the second must not, since it pushes nothing. Two-level nesting, a three-step loop drain and commands that do not match the top frame check that the restore masks are taken from the right frame.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_BRANCH = 3'd1,
        OP_ELSE   = 3'd2,
        OP_JOIN   = 3'd3,
        OP_LOOP   = 3'd4,
        OP_EXIT   = 3'd5
    } mask_op_e;

    typedef enum logic {
        FRAME_IF   = 1'b0,
        FRAME_LOOP = 1'b1
    } frame_kind_e;

    function automatic logic op_pushes(input mask_op_e op);
        return (op == OP_BRANCH) || (op == OP_LOOP);
    endfunction

endpackage

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_mask_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  frame_kind_e       push_kind,
    input  logic [LANES-1:0]  push_reconv,
    input  logic [LANES-1:0]  push_else,
    output frame_kind_e       top_kind,
    output logic [LANES-1:0]  top_reconv,
    output logic [LANES-1:0]  top_else,
    output logic              empty,
    output logic              full,
    output logic [PW-1:0]     count
);

    logic [LANES-1:0] reconv_q [DEPTH];
    logic [LANES-1:0] else_q   [DEPTH];
    frame_kind_e      kind_q   [DEPTH];
    logic [PW-1:0]    cnt_q;

    assign count = cnt_q;
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == PW'(DEPTH));

    // one write port per frame slot, selected by the fill level
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                reconv_q[g] <= '0;
                else_q[g]   <= '0;
                kind_q[g]   <= FRAME_IF;
            end else if (push && !full && (cnt_q == PW'(g))) begin
                reconv_q[g] <= push_reconv;
                else_q[g]   <= push_else;
                kind_q[g]   <= push_kind;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + PW'(1);
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - PW'(1);
        end
    end

    always_comb begin
        top_kind   = FRAME_IF;
        top_reconv = '0;
        top_else   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!empty && (PW'(i) == cnt_q - PW'(1))) begin
                top_kind   = kind_q[i];
                top_reconv = reconv_q[i];
                top_else   = else_q[i];
            end
        end
    end

endmodule

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl
    import simt_mask_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic              valid,
    input  mask_op_e          op,
    input  logic [LANES-1:0]  cond,
    input  logic [LANES-1:0]  cur_mask,
    input  frame_kind_e       top_kind,
    input  logic [LANES-1:0]  top_reconv,
    input  logic [LANES-1:0]  top_else,
    input  logic              stk_empty,
    input  logic              stk_full,
    output logic [LANES-1:0]  nxt_mask,
    output logic              push,
    output logic              pop,
    output frame_kind_e       push_kind,
    output logic [LANES-1:0]  push_reconv,
    output logic [LANES-1:0]  push_else,
    output logic              ovf_set,
    output logic              uni_all,
    output logic              uni_none,
    output logic              drained
);

    logic [LANES-1:0] taken, fallen, remain;
    logic             if_top, loop_top;

    assign taken    = cur_mask & cond;
    assign fallen   = cur_mask & ~cond;
    assign remain   = cur_mask & ~cond;
    assign if_top   = !stk_empty && (top_kind == FRAME_IF);
    assign loop_top = !stk_empty && (top_kind == FRAME_LOOP);

    always_comb begin
        nxt_mask    = cur_mask;
        push        = 1'b0;
        pop         = 1'b0;
        push_kind   = FRAME_IF;
        push_reconv = cur_mask;
        push_else   = fallen;
        ovf_set     = 1'b0;
        uni_all     = 1'b0;
        uni_none    = 1'b0;
        drained     = 1'b0;
        if (valid) begin
            unique case (op)
                OP_BRANCH: begin
                    if (taken == '0) begin
                        uni_none = 1'b1;
                    end else if (fallen == '0) begin
                        uni_all = 1'b1;
                    end else if (stk_full) begin
                        ovf_set = 1'b1;
                    end else begin
                        push     = 1'b1;
                        nxt_mask = taken;
                    end
                end
                OP_ELSE: begin
                    if (if_top) nxt_mask = top_else;
                end
                OP_JOIN: begin
                    if (if_top) begin
                        nxt_mask = top_reconv;
                        pop      = 1'b1;
                    end
                end
                OP_LOOP: begin
                    push_kind = FRAME_LOOP;
                    push_else = '0;
                    if (stk_full) ovf_set = 1'b1;
                    else          push    = 1'b1;
                end
                OP_EXIT: begin
                    if (loop_top) begin
                        if (remain == '0) begin
                            nxt_mask = top_reconv;
                            pop      = 1'b1;
                            drained  = 1'b1;
                        end else begin
                            nxt_mask = remain;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/simt_mask_unit.sv
module simt_mask_unit
    import simt_mask_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [LANES-1:0]  cmd_cond,
    output logic [LANES-1:0]  act_mask,
    output logic              all_go,
    output logic              none_go,
    output logic              loop_done,
    output logic              ovf_err
);

    logic [LANES-1:0] mask_q, nxt_mask;
    logic             push, pop, ovf_set, uni_all, uni_none, drained;
    frame_kind_e      push_kind, top_kind;
    logic [LANES-1:0] push_reconv, push_else, top_reconv, top_else;
    logic             stk_empty, stk_full;
    logic [PW-1:0]    stk_count;
    logic             all_q, none_q, done_q, ovf_q;

    simt_mask_ctrl #(.LANES(LANES)) u_ctrl (
        .valid       (cmd_valid),
        .op          (mask_op_e'(cmd_op)),
        .cond        (cmd_cond),
        .cur_mask    (mask_q),
        .top_kind    (top_kind),
        .top_reconv  (top_reconv),
        .top_else    (top_else),
        .stk_empty   (stk_empty),
        .stk_full    (stk_full),
        .nxt_mask    (nxt_mask),
        .push        (push),
        .pop         (pop),
        .push_kind   (push_kind),
        .push_reconv (push_reconv),
        .push_else   (push_else),
        .ovf_set     (ovf_set),
        .uni_all     (uni_all),
        .uni_none    (uni_none),
        .drained     (drained)
    );

    simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
        .clk         (clk),
        .rst         (rst),
        .push        (push),
        .pop         (pop),
        .push_kind   (push_kind),
        .push_reconv (push_reconv),
        .push_else   (push_else),
        .top_kind    (top_kind),
        .top_reconv  (top_reconv),
        .top_else    (top_else),
        .empty       (stk_empty),
        .full        (stk_full),
        .count       (stk_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            all_q  <= 1'b0;
            none_q <= 1'b0;
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            mask_q <= nxt_mask;
            all_q  <= uni_all;
            none_q <= uni_none;
            done_q <= drained;
            ovf_q  <= ovf_q | ovf_set;
        end
    end

    assign act_mask  = mask_q;
    assign all_go    = all_q;
    assign none_go   = none_q;
    assign loop_done = done_q;
    assign ovf_err   = ovf_q;

endmodule

// File: rtl/simt_mask_chk.sv
module simt_mask_chk #(
    parameter int LANES = 32,
    parameter int PW = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [LANES-1:0] cmd_cond,
    input logic [LANES-1:0] act_mask,
    input logic             all_go,
    input logic             none_go,
    input logic             loop_done,
    input logic             ovf_err,
    input logic [PW-1:0]    depth,
    input logic [LANES-1:0] top_reconv
);

    // R1: the clock edge after a reset cycle leaves every lane live
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (act_mask == '1));

    // R11: live lanes never escape the top frame's restore mask
    p_subset_r11: assert property (@(posedge clk) disable iff (rst)
        (depth != '0) |-> ((act_mask & ~top_reconv) == '0));

    // R9: overflow flag is sticky
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err);

    // R5: uniform branch does not move the mask or the stack
    p_uniform_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd1 &&
         (((act_mask & cmd_cond) == '0) || ((act_mask & ~cmd_cond) == '0)))
        |=> ($stable(act_mask) && $stable(depth)));

    // R5, R8: outcome pulses are mutually exclusive
    p_pulse_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({all_go, none_go, loop_done}));

    // R8: loop completion pops exactly one frame
    p_loop_pop_r8: assert property (@(posedge clk) disable iff (rst)
        loop_done |-> ($past(depth) == depth + PW'(1)));

    // R12: an idle command slot changes nothing
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> ($stable(act_mask) && $stable(depth)));

endmodule

bind simt_mask_unit simt_mask_chk #(.LANES(LANES), .PW(PW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_cond   (cmd_cond),
    .act_mask   (act_mask),
    .all_go     (all_go),
    .none_go    (none_go),
    .loop_done  (loop_done),
    .ovf_err    (ovf_err),
    .depth      (stk_count),
    .top_reconv (top_reconv)
);

// File: tb/test_simt_mask_unit.sv
module test_simt_mask_unit;

    localparam int LANES = 32;
    localparam int DEPTH = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = 3'd0;
    logic [LANES-1:0] cmd_cond = '0;
    logic [LANES-1:0] act_mask;
    logic             all_go, none_go, loop_done, ovf_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [LANES-1:0] m;
        logic             ag, ng, ld, ov;
        string            tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    simt_mask_unit #(.LANES(LANES), .DEPTH(DEPTH)) i_simt_mask_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_cond(cmd_cond), .act_mask(act_mask), .all_go(all_go),
        .none_go(none_go), .loop_done(loop_done), .ovf_err(ovf_err)
    );

    task automatic compare(input exp_t e);
        n_chk++;
        if (act_mask !== e.m || all_go !== e.ag || none_go !== e.ng ||
            loop_done !== e.ld || ovf_err !== e.ov) begin
            n_fail++;
            $display("FAIL %s: got mask=%08h ag=%b ng=%b ld=%b ov=%b, expected mask=%08h ag=%b ng=%b ld=%b ov=%b",
                     e.tag, act_mask, all_go, none_go, loop_done, ovf_err,
                     e.m, e.ag, e.ng, e.ld, e.ov);
        end
    endtask

    // driver: apply one command and queue the outcome expected after the next edge
    task automatic drive(input logic v, input logic [2:0] op, input logic [LANES-1:0] c,
                         input logic [LANES-1:0] em, input logic ag, input logic ng,
                         input logic ld, input logic ov, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_valid = v;
        cmd_op    = op;
        cmd_cond  = c;
        e.m = em; e.ag = ag; e.ng = ng; e.ld = ld; e.ov = ov; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compare away from the active edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        r.m = '1; r.ag = 0; r.ng = 0; r.ld = 0; r.ov = 0; r.tag = "R1 reset state";
        compare(r);

        // even/odd split, else, join
        drive(1, 3'd1, 32'h5555_5555, 32'h5555_5555, 0, 0, 0, 0, "R2 even split then-path");
        drive(1, 3'd2, 32'h0,         32'hAAAA_AAAA, 0, 0, 0, 0, "R3 odd else-path");
        drive(1, 3'd3, 32'h0,         32'hFFFF_FFFF, 0, 0, 0, 0, "R4 join restores warp");

        // uniform outcomes and unmatched commands
        drive(1, 3'd1, 32'h0,         32'hFFFF_FFFF, 0, 1, 0, 0, "R5 none selected");
        drive(1, 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, 0, "R5 all selected");
        drive(1, 3'd3, 32'h0,         32'hFFFF_FFFF, 0, 0, 0, 0, "R10 join on empty stack");
        drive(1, 3'd2, 32'h0,         32'hFFFF_FFFF, 0, 0, 0, 0, "R10 else on empty stack");
        drive(1, 3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, "R10 exit on empty stack");

        // nesting
        drive(1, 3'd1, 32'h0000_FFFF, 32'h0000_FFFF, 0, 0, 0, 0, "R2 outer then");
        drive(1, 3'd1, 32'h00FF_00FF, 32'h0000_00FF, 0, 0, 0, 0, "R6 inner then");
        drive(1, 3'd2, 32'h0,         32'h0000_FF00, 0, 0, 0, 0, "R6 inner else");
        drive(1, 3'd3, 32'h0,         32'h0000_FFFF, 0, 0, 0, 0, "R6 inner join to outer path");
        drive(1, 3'd2, 32'h0,         32'hFFFF_0000, 0, 0, 0, 0, "R3 outer else");
        drive(1, 3'd1, 32'h0000_FFFF, 32'hFFFF_0000, 0, 1, 0, 0, "R5 uniform within else path");
        drive(1, 3'd3, 32'h0,         32'hFFFF_FFFF, 0, 0, 0, 0, "R4 outer join");

        // loop inside a branch
        drive(1, 3'd1, 32'h0000_00FF, 32'h0000_00FF, 0, 0, 0, 0, "R2 branch before loop");
        drive(1, 3'd4, 32'h0,         32'h0000_00FF, 0, 0, 0, 0, "R7 loop enter keeps mask");
        drive(1, 3'd2, 32'h0,         32'h0000_00FF, 0, 0, 0, 0, "R10 else with loop frame on top");
        drive(1, 3'd5, 32'h0000_000F, 32'h0000_00F0, 0, 0, 0, 0, "R7 first exit");
        drive(1, 3'd5, 32'hFFFF_FF30, 32'h0000_00C0, 0, 0, 0, 0, "R7 second exit");
        drive(1, 3'd5, 32'h0000_00C0, 32'h0000_00FF, 0, 0, 1, 0, "R8 drain restores pre-loop mask");
        drive(1, 3'd5, 32'h0000_00FF, 32'h0000_00FF, 0, 0, 0, 0, "R10 exit with branch frame on top");
        drive(1, 3'd3, 32'h0,         32'hFFFF_FFFF, 0, 0, 0, 0, "R4 join after loop");

        // idle and unused codes
        drive(0, 3'd1, 32'h0000_0001, 32'hFFFF_FFFF, 0, 0, 0, 0, "R12 valid low");
        drive(1, 3'd7, 32'h0000_0001, 32'hFFFF_FFFF, 0, 0, 0, 0, "R12 unused code");
        drive(1, 3'd0, 32'h0000_0001, 32'hFFFF_FFFF, 0, 0, 0, 0, "R12 none code");

        // fill the stack, then overflow
        for (int i = 0; i < DEPTH; i++)
            drive(1, 3'd4, 32'h0, 32'hFFFF_FFFF, 0, 0, 0, 0, "R7 loop frame fill");
        drive(1, 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, 0, "R5 uniform at full depth no overflow");
        drive(1, 3'd1, 32'h0000_0001, 32'hFFFF_FFFF, 0, 0, 0, 1, "R9 divergent branch overflows");
        drive(1, 3'd4, 32'h0,         32'hFFFF_FFFF, 0, 0, 0, 1, "R9 loop push overflows");
        drive(1, 3'd0, 32'h0,         32'hFFFF_FFFF, 0, 0, 0, 1, "R9 flag sticky");
        drive(1, 3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1, 1, "R8 drain top loop frame");
        drive(0, 3'd0, 32'h0,         32'hFFFF_FFFF, 0, 0, 0, 1, "R8 pulse lasts one cycle");

        repeat (3) @(posedge clk);
        if (q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: got %0d pending, expected 0", q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule